// File: doc/BRIEF.md
# Paper-Tape Binary Word Assembler

This block listens on a single asynchronous serial line and turns the bytes it receives into 18-bit machine words, using the binary punched-tape convention. An internal 8N1 receiver recovers each character. A byte counts as a data frame only when its most significant bit is set. Its low six bits are a payload, and three payloads in a row make one word.

Bytes that lack the marker bit, and bytes whose stop bit arrives low, are thrown away. They leave the partial word and the frame count exactly as they were. When the third payload lands, the finished word appears on `word_out` together with a single-cycle `word_valid` strobe. The word then stays on `word_out` until the next word completes.

The bit period is `CLK_HZ / BAUD` clock cycles. The defaults are a 50 MHz clock and 115200 baud, which gives 434 cycles per bit.

Top module: `tape_word_builder`

## Requirements
- R1: The receiver decodes characters framed as one low start bit, eight data bits with the least significant bit first, and one stop bit, each bit lasting `CLK_HZ/BAUD` cycles. The line rests high when idle.
- R2: A start is recognised only on a high-to-low transition, and it is confirmed by sampling half a bit later. A low pulse that is high again at that point is dropped, with no effect on the word, the count or `frame_err`.
- R3: Only a byte with bit 7 = 1 is a data frame. A byte with bit 7 = 0 changes neither the partial word nor the frame count.
- R4: The payload of a data frame is byte bits 5..0. Byte bit 6 has no effect on the word.
- R5: Of three data frames, the first goes to word bits 17..12, the second to bits 11..6 and the third to bits 5..0. For example, bytes 0x85, 0x86 and 0xB8 give octal 050670.
- R6: When the third frame is taken, `word_valid` is high for exactly one clock. `word_out` carries the new word in that cycle and does not change until the next word completes.
- R7: After a word completes, the frame count returns to zero, so the next three data frames form a fresh word.
- R8: A stop bit sampled low gives a one-clock pulse on `frame_err`. That byte is discarded even if bit 7 is set.
- R9: A synchronous active-high `rst` clears the partial word, the frame count and `word_out`, and holds `word_valid` and `frame_err` low.
- R10: Idle gaps of any length between characters do not disturb reception or the partial word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| word_out | output | 18 | Last completed word |
| word_valid | output | 1 | One-cycle strobe when a new word is on word_out |
| frame_err | output | 1 | One-cycle strobe when a stop bit was low |

## Verification
The embedded assertions check the following on every cycle:
- both strobes last only one cycle;
- a byte that is not taken leaves the accumulator and the count frozen;
- the frame count stays below three and is zero whenever a word is presented;
- `word_out` only moves together with `word_valid`;
- a start bit is confirmed only when the line is low at mid-bit.

Other behaviour needs the bench's scenarios:
- the bit order on the wire and the packing order of the payloads;
- rejection of short glitches;
- discarding of flagged bytes whose stop bit is bad;
- tolerance of long idle gaps;
- the effect of a reset in the middle of a word.

// File: rtl/tape_pkg.sv
package tape_pkg;

    localparam int BYTE_W   = 8;
    localparam int FLAG_BIT = 7;
    localparam int PAY_W    = 6;
    localparam int FRAMES   = 3;
    localparam int WORD_W   = PAY_W * FRAMES;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;

    // One received character as handed from the receiver to the filter
    typedef struct packed {
        logic              strobe;
        logic [BYTE_W-1:0] data;
        logic              stop_bad;
    } rx_byte_t;

    // A filtered frame: take is high only for a good, flagged byte
    typedef struct packed {
        logic             take;
        logic [PAY_W-1:0] payload;
    } frame_t;

    function automatic int cycles_per_bit(input int clk_hz, input int baud);
        return clk_hz / baud;
    endfunction

endpackage

// File: rtl/tape_uart_rx.sv
module tape_uart_rx
    import tape_pkg::*;
#(
    parameter int BIT_CYC = 434
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rx_line,
    output rx_byte_t rx_o
);
    localparam int HALF  = BIT_CYC / 2;
    localparam int CNT_W = $clog2(BIT_CYC);
    localparam int IDX_W = $clog2(BYTE_W);

    logic [1:0]        sync;
    logic              prev;
    rx_state_t         st;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] sh;
    logic              line;

    assign line = sync[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync <= 2'b11;
            prev <= 1'b1;
            st   <= RX_IDLE;
            cnt  <= '0;
            idx  <= '0;
            sh   <= '0;
            rx_o <= '0;
        end else begin
            sync          <= {sync[0], rx_line};
            prev          <= line;
            rx_o.strobe   <= 1'b0;
            rx_o.stop_bad <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (prev && !line) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                end
                RX_START: begin
                    if (cnt == CNT_W'(HALF - 1)) begin
                        cnt <= '0;
                        idx <= '0;
                        st  <= line ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == CNT_W'(BIT_CYC - 1)) begin
                        cnt <= '0;
                        sh  <= {line, sh[BYTE_W-1:1]};
                        if (idx == IDX_W'(BYTE_W - 1)) st <= RX_STOP;
                        else idx <= idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == CNT_W'(BIT_CYC - 1)) begin
                        cnt           <= '0;
                        st            <= RX_IDLE;
                        rx_o.strobe   <= 1'b1;
                        rx_o.data     <= sh;
                        rx_o.stop_bad <= !line;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    assert_strobe_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        rx_o.strobe |=> !rx_o.strobe);

    assert_ferr_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        rx_o.stop_bad |=> !rx_o.stop_bad);

    assert_start_confirm_R2: assert property (@(posedge clk) disable iff (rst)
        (st == RX_DATA && $past(st) == RX_START) |-> !$past(line));

endmodule

// File: rtl/tape_frame_filter.sv
module tape_frame_filter
    import tape_pkg::*;
(
    input  rx_byte_t rx_i,
    output frame_t   fr_o
);
    always_comb begin
        fr_o.take    = rx_i.strobe && !rx_i.stop_bad && rx_i.data[FLAG_BIT];
        fr_o.payload = rx_i.data[PAY_W-1:0];
    end
endmodule

// File: rtl/tape_word_accum.sv
module tape_word_accum
    import tape_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  frame_t            fr_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);
    localparam int CW = $clog2(FRAMES);

    logic [WORD_W-1:0] acc;
    logic [CW-1:0]     cnt;
    logic [WORD_W-1:0] next_acc;

    assign next_acc = {acc[WORD_W-PAY_W-1:0], fr_i.payload};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            cnt     <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (fr_i.take) begin
                acc <= next_acc;
                if (cnt == CW'(FRAMES - 1)) begin
                    cnt     <= '0;
                    word_o  <= next_acc;
                    valid_o <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assert_ignore_R3: assert property (@(posedge clk) disable iff (rst)
        !fr_i.take |=> ($stable(acc) && $stable(cnt)));

    assert_cnt_range_R7: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(FRAMES));

    assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (cnt == '0));

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(word_o));

endmodule

// File: rtl/tape_word_builder.sv
module tape_word_builder
    import tape_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 115_200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic              frame_err
);
    localparam int BIT_CYC = cycles_per_bit(CLK_HZ, BAUD);

    rx_byte_t rx_b;
    frame_t   fr;

    tape_uart_rx #(.BIT_CYC(BIT_CYC)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .rx_line (rx_line),
        .rx_o    (rx_b)
    );

    tape_frame_filter u_filt (
        .rx_i (rx_b),
        .fr_o (fr)
    );

    tape_word_accum u_acc (
        .clk     (clk),
        .rst     (rst),
        .fr_i    (fr),
        .word_o  (word_out),
        .valid_o (word_valid)
    );

    assign frame_err = rx_b.stop_bad;

    assert_word_from_frame_R5: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(fr.take));

    assert_err_not_taken_R8: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> !fr.take);

endmodule

// File: tb/test_tape_word_builder.sv
module test_tape_word_builder;
    localparam int CLK_HZ = 50_000_000;
    localparam int BAUD   = 3_125_000;
    localparam int BITC   = CLK_HZ / BAUD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_line = 1'b1;
    logic [17:0] word_out;
    logic        word_valid;
    logic        frame_err;

    int n_cmp = 0;
    int n_bad = 0;
    int seen_words = 0;
    int seen_ferr = 0;
    int double_pulse = 0;
    logic last_valid = 1'b0;
    int cyc = 0;

    // bench reference model
    logic [17:0] m_acc = '0;
    int          m_cnt = 0;
    logic [17:0] m_last = '0;
    int          m_words = 0;
    int          m_ferr = 0;

    always #4 clk = ~clk;

    tape_word_builder #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) i_tape_word_builder (
        .clk        (clk),
        .rst        (rst),
        .rx_line    (rx_line),
        .word_out   (word_out),
        .word_valid (word_valid),
        .frame_err  (frame_err)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (word_valid) seen_words <= seen_words + 1;
        if (frame_err)  seen_ferr  <= seen_ferr + 1;
        if (word_valid && last_valid) double_pulse <= double_pulse + 1;
        last_valid <= word_valid;
    end

    function automatic logic [17:0] pack3(input logic [7:0] a, input logic [7:0] b,
                                          input logic [7:0] c);
        return {a[5:0], b[5:0], c[5:0]};
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v);
        rx_line = v;
        repeat (BITC) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit stop_ok, input int gap);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(b[i]);
        drive_bit(stop_ok);
        rx_line = 1'b1;
        if (!stop_ok) m_ferr++;
        else if (b[7]) begin
            m_acc = {m_acc[11:0], b[5:0]};
            m_cnt++;
            if (m_cnt == 3) begin
                m_cnt = 0;
                m_last = m_acc;
                m_words++;
            end
        end
        repeat (gap) @(negedge clk);
    endtask

    task automatic check_state(input string tag);
        check(seen_words == m_words, tag, seen_words, m_words);
        check(word_out == m_last, tag, word_out, m_last);
        check(seen_ferr == m_ferr, tag, seen_ferr, m_ferr);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_acc = '0;
        m_cnt = 0;
        m_last = '0;
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        wait (cyc > 190_000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        logic [7:0] b0, b1, b2;
        int unsigned r;
        r = $urandom(32'h5EED_1234);
        repeat (4) @(negedge clk);
        // R9: reset values
        check(word_out == 18'd0, "R9 reset word", word_out, 0);
        check(word_valid == 1'b0, "R9 reset valid", word_valid, 0);
        check(frame_err == 1'b0, "R9 reset ferr", frame_err, 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);

        // R5 and R3: directed word with an unflagged byte in the middle
        send_byte(8'h85, 1'b1, 25);
        send_byte(8'h3F, 1'b1, 25);
        check(seen_words == 0, "R3 unflagged no word", seen_words, 0);
        send_byte(8'h86, 1'b1, 25);
        send_byte(8'hB8, 1'b1, 25);
        check(word_out == 18'o050670, "R5 octal 050670", word_out, 18'o050670);
        check_state("R1 directed");

        // R4: bit 6 set on every frame gives the same word
        send_byte(8'hC5, 1'b1, 25);
        send_byte(8'hC6, 1'b1, 25);
        send_byte(8'hF8, 1'b1, 25);
        check(word_out == 18'o050670, "R4 bit6 ignored", word_out, 18'o050670);
        check(seen_words == 2, "R7 second word", seen_words, 2);

        // R2: glitch in the middle of a word
        send_byte(8'hA1, 1'b1, 25);
        rx_line = 1'b0;
        repeat (3) @(negedge clk);
        rx_line = 1'b1;
        repeat (40) @(negedge clk);
        check_state("R2 glitch");
        // R8: flagged byte with a low stop bit in the middle of the word
        send_byte(8'hBF, 1'b0, 40);
        check(seen_ferr == 1, "R8 ferr pulse", seen_ferr, 1);
        send_byte(8'h92, 1'b1, 25);
        // R10: long idle gap before the last frame
        repeat (2000) @(negedge clk);
        send_byte(8'h8C, 1'b1, 25);
        check(word_out == pack3(8'hA1, 8'h92, 8'h8C), "R10 gap word", word_out,
              pack3(8'hA1, 8'h92, 8'h8C));
        check_state("R8 after error");

        // R9: reset in the middle of a word
        send_byte(8'hAA, 1'b1, 25);
        do_reset();
        check(word_out == 18'd0, "R9 mid reset word", word_out, 0);
        send_byte(8'h81, 1'b1, 25);
        send_byte(8'h82, 1'b1, 25);
        send_byte(8'h83, 1'b1, 25);
        check(word_out == pack3(8'h81, 8'h82, 8'h83), "R9 fresh word", word_out,
              pack3(8'h81, 8'h82, 8'h83));
        check_state("R7 after reset");

        // R1, R3, R5, R6, R7: random words with random unflagged bytes
        for (int w = 0; w < 40; w++) begin
            b0 = 8'($urandom) | 8'h80;
            b1 = 8'($urandom) | 8'h80;
            b2 = 8'($urandom) | 8'h80;
            send_byte(b0, 1'b1, 20 + int'($urandom % 40));
            if ($urandom % 3 == 0) send_byte(8'($urandom) & 8'h7F, 1'b1, 20);
            send_byte(b1, 1'b1, 20 + int'($urandom % 40));
            if ($urandom % 3 == 0) send_byte(8'($urandom) & 8'h7F, 1'b1, 20);
            send_byte(b2, 1'b1, 20 + int'($urandom % 40));
            check(word_out == pack3(b0, b1, b2), "R5 random word", word_out, pack3(b0, b1, b2));
            if (w % 8 == 0) check_state("R1 random");
        end
        check_state("R6 final");
        check(double_pulse == 0, "R6 single pulse", double_pulse, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule